// File: doc/BRIEF.md
# Error Interrupt Status Bank with Software Event Injection

This block keeps the error interrupt state of one SD/MMC host controller channel. Three 16-bit registers sit behind a small register bus: a status register that latches error events, a status-enable mask that decides which events may latch, and a signal-enable mask that decides which latched events drive the interrupt line. A fourth, write-only address has no storage. Writing a 1 there injects an error event into the status register, so software can exercise its interrupt handlers without provoking real bus faults.

Hardware error pulses from the command and data paths arrive on a 10-bit input. They are gated by the status-enable mask in the same way as injected events. Software clears a latched bit by writing a 1 to it. The interrupt output is a registered level. A combinational summary flag reports whether any status bit is set, so that a neighbouring normal-interrupt register can mirror it.

Register addresses (2-bit word address): 0 status, 1 status enable, 2 signal enable, 3 event injection.

Top module: `err_irq_bank`

## Requirements
- R1: After reset, all three registers read 0x0000, `err_irq` is 0 and `error_any` is 0.
- R2: Reads at address 0, 1 and 2 return the status, status-enable and signal-enable registers. A read at the injection address 3 always returns 0x0000.
- R3: A write at address 3 sets each status bit whose data bit is 1 and whose status-enable bit is 1. Data bits at 0 leave the status unchanged. Bit meanings: 0 command timeout, 1 command CRC, 2 command end bit, 3 command index, 4 data timeout, 5 data CRC, 6 data end bit, 8 auto stop-command error, 9 scatter-gather DMA error.
- R4: An injected or hardware event on a bit whose status-enable bit is 0 does not set that status bit. The mask in use is the status-enable value held before the cycle of the event.
- R5: A 1 on `hw_err[i]` in a cycle sets status bit i at the next clock edge when status-enable bit i is 1, for i in 0..6, 8 and 9.
- R6: A write at address 0 clears each status bit whose data bit is 1. Data bits at 0 leave the status unchanged.
- R7: When a set (hardware or injected) and a clear reach the same status bit in the same cycle, the bit ends up set.
- R8: Bit 7 and bits 15:10 are reserved in every register. They are never set and always read 0, and writes of 1 to them are dropped.
- R9: `err_irq` is registered. It equals, one clock after, the OR over all bits of status AND status-enable AND signal-enable.
- R10: Clearing a status-enable bit keeps an already latched status bit, but that bit no longer drives `err_irq`.
- R11: `error_any` is 1 in exactly the cycles in which the status register is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| hw_err | input | 10 | Hardware error pulses, one cycle per event |
| err_irq | output | 1 | Error interrupt, registered level |
| error_any | output | 1 | High while any status bit is set |

## Verification
On every cycle, the assertions check four things: reserved bits stay at zero, a read of the injection address returns zero, no status bit rises unless its enable was set, and a cleared bit stays clear unless a set arrived in the same cycle. They also check that `err_irq` follows the masked OR with a delay of one clock. Only the bench scenarios can show the register map at work. These include the per-bit sweep of injection and clearing, hardware pulses per bit, the set-beats-clear collision, and the full cross of enable masks with retained status. They also show that the interrupt still holds its old value in the cycle right after an enable change.

// File: rtl/err_irq_bank.sv
module err_irq_bank #(
  parameter int DATA_W = 16,
  parameter int HW_W   = 10,
  parameter logic [DATA_W-1:0] IMPL_MASK = 16'h037F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [HW_W-1:0]   hw_err,
  output logic              err_irq,
  output logic              error_any
);

  localparam logic [1:0] A_STS = 2'd0;
  localparam logic [1:0] A_SEN = 2'd1;
  localparam logic [1:0] A_SIG = 2'd2;
  localparam logic [1:0] A_INJ = 2'd3;

  logic [DATA_W-1:0] status, stat_en, sig_en;
  logic [DATA_W-1:0] hw_ext, inj_req, set_req, clr_req;

  assign hw_ext  = DATA_W'(hw_err);
  assign inj_req = (bus_wr && bus_addr == A_INJ) ? bus_wdata : '0;
  assign clr_req = (bus_wr && bus_addr == A_STS) ? bus_wdata : '0;
  assign set_req = (hw_ext | inj_req) & stat_en & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status  <= '0;
      stat_en <= '0;
      sig_en  <= '0;
      err_irq <= 1'b0;
    end else begin
      status  <= (status & ~clr_req) | set_req;
      if (bus_wr && bus_addr == A_SEN) stat_en <= bus_wdata & IMPL_MASK;
      if (bus_wr && bus_addr == A_SIG) sig_en  <= bus_wdata & IMPL_MASK;
      err_irq <= |(status & stat_en & sig_en);
    end
  end

  assign error_any = |status;

  always_comb begin
    case (bus_addr)
      A_STS:   bus_rdata = status;
      A_SEN:   bus_rdata = stat_en;
      A_SIG:   bus_rdata = sig_en;
      default: bus_rdata = '0;
    endcase
  end

endmodule

module err_irq_bank_chk #(
  parameter int DATA_W = 16,
  parameter int HW_W   = 10,
  parameter logic [DATA_W-1:0] IMPL_MASK = 16'h037F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [HW_W-1:0]   hw_err,
  input logic              err_irq,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] stat_en,
  input logic [DATA_W-1:0] sig_en
);

  logic [DATA_W-1:0] any_set;
  assign any_set = DATA_W'(hw_err) | ((bus_wr && bus_addr == 2'd3) ? bus_wdata : '0);

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status | stat_en | sig_en) & ~IMPL_MASK) == '0);

  assert_inject_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));

  assert_rise_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & ~$past(stat_en)) == '0);

  assert_clear_unless_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=>
      ((status & $past(bus_wdata) & ~($past(any_set) & $past(stat_en))) == '0));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq == $past(|(status & stat_en & sig_en)));

endmodule

bind err_irq_bank err_irq_bank_chk #(.DATA_W(DATA_W), .HW_W(HW_W), .IMPL_MASK(IMPL_MASK)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_err(hw_err),
  .err_irq(err_irq), .status(status), .stat_en(stat_en), .sig_en(sig_en)
);

// File: tb/err_irq_bank_tb.sv
module err_irq_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VALID = 16'h037F;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [9:0] hw_err = '0;
  logic err_irq, error_any;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_sts = '0, m_sen = '0, m_sig = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_irq_bank dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_err(hw_err),
    .err_irq(err_irq), .error_any(error_any));

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d, logic [9:0] hw = '0);
    logic [15:0] set;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; hw_err = hw;
    set = ({6'd0, hw} | (a == 2'd3 ? d : 16'h0)) & m_sen & VALID;
    m_sts = (m_sts & ~(a == 2'd0 ? d : 16'h0)) | set;
    if (a == 2'd1) m_sen = d & VALID;
    if (a == 2'd2) m_sig = d & VALID;
    @(negedge clk);
    bus_wr = 1'b0; hw_err = '0;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
    bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, 16'h0, "R1 status reset"); rd(1, 16'h0, "R1 sen reset"); rd(2, 16'h0, "R1 sig reset");
    check("R1 irq reset", {15'd0, err_irq}, 16'h0);
    check("R1 any reset", {15'd0, error_any}, 16'h0);

    wr(1, 16'hFFFF); rd(1, VALID, "R8 sen reserved");
    wr(2, 16'hFFFF); rd(2, VALID, "R8 sig reserved");
    rd(3, 16'h0, "R2 inject reads zero");

    for (int b = 0; b < 16; b++) begin
      wr(3, 16'h1 << b);
      rd(0, m_sts, "R3 inject bit");
      check("R11 any after inject", {15'd0, error_any}, {15'd0, m_sts != 0});
      rd(3, 16'h0, "R2 inject readback");
      wr(0, 16'hFFFF);
      rd(0, 16'h0, "R6 clear all");
      check("R11 any after clear", {15'd0, error_any}, 16'h0);
    end

    wr(3, 16'h0005); wr(3, 16'h0000); rd(0, 16'h0005, "R3 zero no effect");
    wr(0, 16'h0000); rd(0, 16'h0005, "R6 write zero keeps");
    wr(0, 16'h0001); rd(0, 16'h0004, "R6 partial clear");
    wr(0, 16'hFFFF);

    for (int b = 0; b < 10; b++) begin
      wr(2, m_sig, 10'h1 << b);
      rd(0, m_sts, "R5 hw pulse");
    end
    check("R5 hw bits expected", m_sts, 16'h037F);
    wr(0, 16'hFFFF);

    wr(1, 16'h0);
    wr(3, 16'hFFFF); rd(0, 16'h0, "R4 inject masked");
    wr(2, m_sig, 10'h3FF); rd(0, 16'h0, "R4 hw masked");

    wr(1, 16'h0001); wr(3, 16'h0001);
    wr(0, 16'h0001, 10'h001); rd(0, 16'h0001, "R7 set beats clear");
    wr(0, 16'h0001); rd(0, 16'h0000, "R7 clear afterwards");

    wr(1, 16'h000F); wr(3, 16'h000F);
    for (int a = 0; a < 16; a++) begin
      for (int s = 0; s < 16; s++) begin
        wr(1, 16'(a)); wr(2, 16'(s));
        rd(0, 16'h000F, "R10 status kept");
        settle();
        check("R9 irq masked cross", {15'd0, err_irq}, {15'd0, |(m_sts & m_sen & m_sig)});
      end
    end

    wr(1, 16'h0001); wr(2, 16'h0001); settle();
    check("R9 irq high", {15'd0, err_irq}, 16'h1);
    wr(1, 16'h0000);
    check("R9 irq delay old", {15'd0, err_irq}, 16'h1);
    settle();
    check("R10 irq masked", {15'd0, err_irq}, 16'h0);
    rd(0, 16'h000F, "R10 latched retained");
    check("R11 any retained", {15'd0, error_any}, 16'h1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule